// File: doc/BRIEF.md
# Frame-buffer rectangle fill engine

The engine takes one fill command and writes a solid rectangle of one colour into a frame buffer of 1024 x 512 halfwords. A command holds a 15-bit colour, a start column, a start row, a width and a height. Before any write, the engine normalises these values. The start column is aligned down to a 16-halfword boundary. The start row and the height are cut to 9 bits. The width is rounded up to a multiple of 16 halfwords, taken modulo 1024. The engine then walks the rectangle row by row. Within each row it goes column by column, and it issues one halfword write per accepted memory handshake. Coordinates wrap at the right and bottom edges of the buffer.

Commands arrive over a valid/ready pair and are taken only while the engine is idle. Writes leave over a valid/ready pair that carries a linear halfword address and the data. The memory's per-halfword write-protect bit plays no part: the engine never reads memory and overwrites every covered halfword. A one-cycle `done` pulse marks the end of each command, including commands that turn out empty.

The controller is a four-state machine:
- `ST_IDLE` goes to `ST_SETUP` when a command is accepted.
- `ST_SETUP` goes to `ST_DONE` when the normalised rectangle is empty, and to `ST_WALK` otherwise.
- `ST_WALK` goes to `ST_DONE` once the last write is accepted.
- `ST_DONE` always returns to `ST_IDLE`.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, and after any reset asserted in mid-command, `cmd_ready`=1, `busy`=0, `done`=0 and `wr_valid`=0.
- R2: The first column is `cmd_x & 0x3F0` and the first row is `cmd_y & 0x1FF`. Writes go in row-major order with `wr_addr` = {row[8:0], column[9:0]}, so the address is row*1024 + column.
- R3: The effective width is `((cmd_w & 0x3FF) + 15) & ~15`. Width values 0x3F1 to 0x3FF therefore give 1024 columns. Each row holds exactly that many writes.
- R4: When `cmd_w & 0x3FF` is zero, for example when `cmd_w` is 0x400 or 0x000, no write is issued and `done` still pulses.
- R5: The effective height is `cmd_h & 0x1FF`, so at most 511 rows are filled. A height of 0x200 produces no write.
- R6: The column wraps modulo 1024 and the row wraps modulo 512 when the rectangle crosses a buffer edge.
- R7: `wr_data` = {1'b0, colour} on every write. Every covered halfword is written exactly once and unconditionally, with no read and no write-protect check, so the write count equals width x height.
- R8: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle. The engine advances only on an accepted write.
- R9: `done` is high for exactly one cycle. That cycle is the one after the last accepted write, or the second cycle after acceptance for an empty command. The engine is idle in the cycle that follows.
- R10: `cmd_ready` is high only while `busy` is low. A command is taken on `cmd_valid && cmd_ready`, and `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_color | input | 15 | Fill colour |
| cmd_x | input | 16 | Raw start column |
| cmd_y | input | 16 | Raw start row |
| cmd_w | input | 16 | Raw width |
| cmd_h | input | 16 | Raw height |
| wr_valid | output | 1 | Write request present |
| wr_ready | input | 1 | Memory takes the write |
| wr_addr | output | 19 | Linear halfword address {row, column} |
| wr_data | output | 16 | Halfword to store |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |

## Verification
A wrong column or row counter shows up at the first write after the error as an address that leaves the expected row-major sequence. A wrong rounding or masking result shows up only at `done`, as a write count that differs from width x height, and it is visible within one command. A state machine stuck in `ST_WALK` or `ST_DONE` holds `busy` high and `cmd_ready` low on the following cycle. A step taken during a stall changes `wr_addr` in the cycle after `wr_ready` was low.

// File: rtl/rfill_pkg.sv
package rfill_pkg;

    localparam int RF_XBITS = 10;  // log2 of buffer width in halfwords
    localparam int RF_YBITS = 9;   // log2 of buffer height in rows
    localparam int RF_ALIGN = 4;   // log2 of width/start granularity
    localparam int RF_PW    = 16;  // raw command parameter width
    localparam int RF_CW    = 15;  // colour width

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WALK  = 2'd2,
        ST_DONE  = 2'd3
    } rfill_state_e;

endpackage

// File: rtl/rfill_geom.sv
// Normalises raw command geometry: start alignment, masking, width rounding.
module rfill_geom #(
    parameter int XBITS = rfill_pkg::RF_XBITS,
    parameter int YBITS = rfill_pkg::RF_YBITS,
    parameter int ALIGN = rfill_pkg::RF_ALIGN,
    parameter int PW    = rfill_pkg::RF_PW
) (
    input  logic [PW-1:0] p_x,
    input  logic [PW-1:0] p_y,
    input  logic [PW-1:0] p_w,
    input  logic [PW-1:0] p_h,
    output logic [PW-1:0] x0,
    output logic [PW-1:0] y0,
    output logic [PW-1:0] w_eff,
    output logic [PW-1:0] h_eff,
    output logic          empty
);
    localparam logic [PW-1:0] XSPAN = PW'((1 << XBITS) - 1);
    localparam logic [PW-1:0] YSPAN = PW'((1 << YBITS) - 1);
    localparam logic [PW-1:0] ROUND = PW'((1 << ALIGN) - 1);
    localparam logic [PW-1:0] XMASK = XSPAN & ~ROUND;

    always_comb begin
        x0    = p_x & XMASK;
        y0    = p_y & YSPAN;
        w_eff = ((p_w & XSPAN) + ROUND) & ~ROUND;
        h_eff = p_h & YSPAN;
        empty = (w_eff == '0) || (h_eff == '0);
    end
endmodule

// File: rtl/rfill_walker.sv
// Column/row counters and wrapped address generation.
module rfill_walker #(
    parameter int XBITS = rfill_pkg::RF_XBITS,
    parameter int YBITS = rfill_pkg::RF_YBITS,
    parameter int PW    = rfill_pkg::RF_PW,
    localparam int AW   = XBITS + YBITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [PW-1:0] x0,
    input  logic [PW-1:0] y0,
    input  logic [PW-1:0] w_eff,
    input  logic [PW-1:0] h_eff,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [XBITS-1:0] col_q;
    logic [YBITS-1:0] row_q;
    logic             col_end;
    logic             row_end;

    always_comb begin
        col_end = (PW'(col_q) == w_eff - PW'(1));
        row_end = (PW'(row_q) == h_eff - PW'(1));
        last    = col_end && row_end;
        addr    = {YBITS'(y0 + PW'(row_q)), XBITS'(x0 + PW'(col_q))};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (load) begin
            col_q <= '0;
            row_q <= '0;
        end else if (step) begin
            if (col_end) begin
                col_q <= '0;
                row_q <= row_q + YBITS'(1);
            end else begin
                col_q <= col_q + XBITS'(1);
            end
        end
    end
endmodule

// File: rtl/rfill_ctrl.sv
// Command sequencing state machine.
module rfill_ctrl
    import rfill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic wr_ready,
    input  logic empty,
    input  logic last,
    output logic cmd_ready,
    output logic take,
    output logic load,
    output logic step,
    output logic wr_valid,
    output logic busy,
    output logic done
);
    rfill_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_SETUP;
            ST_SETUP: state_d = empty ? ST_DONE : ST_WALK;
            ST_WALK:  if (wr_ready && last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        take      = cmd_ready && cmd_valid;
        load      = (state_q == ST_SETUP);
        wr_valid  = (state_q == ST_WALK);
        step      = wr_valid && wr_ready;
        done      = (state_q == ST_DONE);
        busy      = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine #(
    parameter int XBITS = rfill_pkg::RF_XBITS,
    parameter int YBITS = rfill_pkg::RF_YBITS,
    parameter int ALIGN = rfill_pkg::RF_ALIGN,
    parameter int PW    = rfill_pkg::RF_PW,
    parameter int CW    = rfill_pkg::RF_CW,
    localparam int AW   = XBITS + YBITS,
    localparam int DW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [CW-1:0] cmd_color,
    input  logic [PW-1:0] cmd_x,
    input  logic [PW-1:0] cmd_y,
    input  logic [PW-1:0] cmd_w,
    input  logic [PW-1:0] cmd_h,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          done
);
    logic [PW-1:0] x_q, y_q, w_q, h_q;
    logic [CW-1:0] color_q;
    logic [PW-1:0] x0, y0, w_eff, h_eff;
    logic          empty, last, take, load, step;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q     <= '0;
            y_q     <= '0;
            w_q     <= '0;
            h_q     <= '0;
            color_q <= '0;
        end else if (take) begin
            x_q     <= cmd_x;
            y_q     <= cmd_y;
            w_q     <= cmd_w;
            h_q     <= cmd_h;
            color_q <= cmd_color;
        end
    end

    rfill_geom #(.XBITS(XBITS), .YBITS(YBITS), .ALIGN(ALIGN), .PW(PW)) u_geom (
        .p_x(x_q), .p_y(y_q), .p_w(w_q), .p_h(h_q),
        .x0(x0), .y0(y0), .w_eff(w_eff), .h_eff(h_eff), .empty(empty)
    );

    rfill_walker #(.XBITS(XBITS), .YBITS(YBITS), .PW(PW)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .x0(x0), .y0(y0), .w_eff(w_eff), .h_eff(h_eff),
        .addr(wr_addr), .last(last)
    );

    rfill_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_ready(wr_ready),
        .empty(empty), .last(last), .cmd_ready(cmd_ready), .take(take),
        .load(load), .step(step), .wr_valid(wr_valid), .busy(busy), .done(done)
    );

    assign wr_data = {1'b0, color_q};
endmodule

// File: rtl/rfill_chk.sv
module rfill_chk #(
    parameter int XBITS = rfill_pkg::RF_XBITS,
    parameter int YBITS = rfill_pkg::RF_YBITS,
    parameter int ALIGN = rfill_pkg::RF_ALIGN,
    parameter int PW    = rfill_pkg::RF_PW,
    parameter int DW    = rfill_pkg::RF_CW + 1,
    localparam int AW   = XBITS + YBITS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [PW-1:0] cmd_w,
    input logic [PW-1:0] cmd_h,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          busy,
    input logic          done
);
    logic [31:0] exp_q, cnt_q;

    function automatic logic [31:0] area(input logic [PW-1:0] w, input logic [PW-1:0] h);
        int wm, ew, eh;
        wm = int'(w) & ((1 << XBITS) - 1);
        ew = (wm == 0) ? 0 : ((((wm - 1) >> ALIGN) + 1) << ALIGN);
        eh = int'(h) & ((1 << YBITS) - 1);
        return 32'(ew * eh);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q <= '0;
            cnt_q <= '0;
        end else if (cmd_valid && cmd_ready) begin
            exp_q <= area(cmd_w, cmd_h);
            cnt_q <= '0;
        end else if (wr_valid && wr_ready) begin
            cnt_q <= cnt_q + 32'd1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !busy && !wr_valid);
    p_area_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> cnt_q == exp_q);
    p_data_top_r7: assert property (@(posedge clk) disable iff (!rst_n) wr_valid |-> !wr_data[DW-1]);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done && !busy);
    p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) cmd_ready |-> !busy);
    p_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> busy && !cmd_ready);
endmodule

bind rect_fill_engine rfill_chk #(
    .XBITS(XBITS), .YBITS(YBITS), .ALIGN(ALIGN), .PW(PW), .DW(DW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_w(cmd_w), .cmd_h(cmd_h), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
);

// File: tb/sim_rect_fill_engine.sv
`timescale 1ns/1ps
module sim_rect_fill_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [14:0] cmd_color = '0;
    logic [15:0] cmd_x = '0, cmd_y = '0, cmd_w = '0, cmd_h = '0;
    logic        wr_valid;
    logic        wr_ready = 1'b1;
    logic [18:0] wr_addr;
    logic [15:0] wr_data;
    logic        busy, done;

    int n_checks = 0;
    int n_fail = 0;
    int stall_ctr = 0;
    bit finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    rect_fill_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_color(cmd_color), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w),
        .cmd_h(cmd_h), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
    );

    // {x, y, w, h, exp_x, exp_y, exp_w, exp_h}
    localparam logic [127:0] VEC [0:9] = '{
        {16'h0000, 16'h0000, 16'h0010, 16'h0001, 16'h0000, 16'h0000, 16'h0010, 16'h0001},
        {16'h0025, 16'h0003, 16'h0011, 16'h0003, 16'h0020, 16'h0003, 16'h0020, 16'h0003},
        {16'h03FF, 16'h01FF, 16'h0020, 16'h0002, 16'h03F0, 16'h01FF, 16'h0020, 16'h0002},
        {16'h0000, 16'h0005, 16'h0400, 16'h0004, 16'h0000, 16'h0005, 16'h0000, 16'h0004},
        {16'h0010, 16'h0000, 16'h03F1, 16'h0001, 16'h0010, 16'h0000, 16'h0400, 16'h0001},
        {16'h0000, 16'h0000, 16'h0010, 16'h0200, 16'h0000, 16'h0000, 16'h0010, 16'h0000},
        {16'h0000, 16'h0000, 16'h0000, 16'h0005, 16'h0000, 16'h0000, 16'h0000, 16'h0005},
        {16'h8013, 16'hFE07, 16'h0405, 16'h0202, 16'h0010, 16'h0007, 16'h0010, 16'h0002},
        {16'h0100, 16'h0100, 16'h03FF, 16'h0001, 16'h0100, 16'h0100, 16'h0400, 16'h0001},
        {16'h0040, 16'h0010, 16'h0001, 16'h01FF, 16'h0040, 16'h0010, 16'h0010, 16'h01FF}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_cmd(input int idx, input logic [15:0] px, py, pw, ph,
                           input int ex, ey, ew, eh);
        logic [14:0] colr;
        int n, r, c, guard, expn, ea;
        bit seen, stalled;
        logic [18:0] hold_a;
        string ctag;
        colr = 15'h2A5B ^ 15'(idx * 613);
        expn = ew * eh;
        n = 0; r = 0; c = 0; guard = 0; seen = 0; stalled = 0; hold_a = '0;
        ctag = (ew == 0) ? "R4" : ((eh == 0) ? "R5" : "R3");
        @(negedge clk);
        cmd_x = px; cmd_y = py; cmd_w = pw; cmd_h = ph; cmd_color = colr;
        cmd_valid = 1'b1;
        chk(cmd_ready == 1'b1, "R10", "ready while idle", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy && !cmd_ready, "R10", "busy after take", {busy, cmd_ready}, 2'b10);
        while (!seen && guard < 20000) begin
            if (stalled)
                chk(wr_valid && wr_addr == hold_a, "R8", "held during stall", wr_addr, hold_a);
            wr_ready = (stall_ctr % 4) != 3;
            stall_ctr++;
            if (done) begin
                seen = 1;
                chk(n == expn, ctag, "write count", n, expn);
            end else if (wr_valid && wr_ready) begin
                ea = (((ey + r) & 511) << 10) | ((ex + c) & 1023);
                chk(int'(wr_addr) == ea,
                    ((ex + c) > 1023 || (ey + r) > 511) ? "R6" : "R2",
                    "address", wr_addr, ea);
                chk(wr_data == {1'b0, colr}, "R7", "data", wr_data, {1'b0, colr});
                n++;
                c++;
                if (c == ew) begin c = 0; r++; end
            end
            stalled = wr_valid && !wr_ready;
            hold_a = wr_addr;
            if (!seen) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(seen, "R9", "done pulse seen", seen, 1);
        @(negedge clk);
        chk(!done && !busy && cmd_ready, "R9", "single pulse then idle",
            {done, busy, cmd_ready}, 3'b001);
        wr_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_ready && !busy && !done && !wr_valid, "R1", "reset state",
            {cmd_ready, busy, done, wr_valid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready && !busy && !done && !wr_valid, "R1", "idle after reset",
            {cmd_ready, busy, done, wr_valid}, 4'b1000);

        for (int i = 0; i < 10; i++) begin
            run_cmd(i, VEC[i][127:112], VEC[i][111:96], VEC[i][95:80], VEC[i][79:64],
                    int'(VEC[i][63:48]), int'(VEC[i][47:32]),
                    int'(VEC[i][31:16]), int'(VEC[i][15:0]));
        end

        // Reset asserted while a fill is walking
        @(negedge clk);
        cmd_x = 16'h0; cmd_y = 16'h0; cmd_w = 16'h40; cmd_h = 16'h4; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk(wr_valid, "R1", "walking before reset", wr_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cmd_ready && !busy && !done && !wr_valid, "R1", "reset mid-command",
            {cmd_ready, busy, done, wr_valid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(20, 16'h0033, 16'h0044, 16'h0021, 16'h0002, 32'h30, 32'h44, 32'h30, 32'h2);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule